// File: doc/BRIEF.md
# Tagged Integer Add/Subtract Unit

This block performs add and subtract on tagged integers and produces the condition flags. A tagged integer keeps a type tag in its two lowest bits. The arithmetic paths assume that both tags are zero. If either operand carries a nonzero tag, the unit reports it as an overflow. Four operations are available: plain tagged add, plain tagged subtract, and a trapping form of each. A plain operation always writes back its result, and tag trouble shows only in the V flag. A trapping operation either completes cleanly with V cleared, or aborts with a trap request and writes nothing.

The data path is 32 or 64 bits wide, chosen by a parameter. In 32-bit mode only the 32-bit flag set is live. In 64-bit mode the 32-bit flags are taken from the low word, and a second flag set describes the full 64-bit result. Every output is registered and appears one cycle after an accepted input. The register file, decode and trap vectoring are not part of this block.

Top module: `tag_alu`

## Requirements
- R1: While `rst_n` is low, every output is driven to zero on each rising clock edge.
- R2: An input with `in_valid` high and `op_sel` equal to 0x20, 0x21, 0x22 or 0x23 produces a one-cycle `out_valid` pulse on the next edge. Any other code, or `in_valid` low, gives no `out_valid`, `wr_en`, `flag_wr` or `trap_req`, and `result` keeps its previous value.
- R3: `op_sel` bit 0 selects subtract (first minus second) over add, and bit 1 selects the trapping form. `result` is the wrapped sum or difference at the data width.
- R4: For 0x20 and 0x21, the 32-bit V flag is set when either operand has a nonzero value in bits [1:0], even when there is no signed overflow.
- R5: For 0x20 and 0x21, the 32-bit V flag is also set on signed 32-bit overflow. For add, this means the operand signs agree and the result sign differs. For subtract, it means the operand signs differ and the result sign differs from the first operand.
- R6: C is the unsigned carry-out for add and the unsigned borrow (first < second) for subtract.
- R7: N is the sign bit and Z flags an all-zero result. Each flag vector is packed as {N,Z,V,C} at bits [3:0].
- R8: A trapping operation traps when either tag is nonzero or a signed 32-bit overflow occurs. It then pulses `trap_req` with `trap_code` 0x23 in 64-bit mode or 0x0a in 32-bit mode. `wr_en` and `flag_wr` stay low, and `result`, `icc` and `xcc` read zero. `trap_code` is zero whenever no trap is pulsed.
- R9: A trapping operation that does not trap pulses `wr_en` and `flag_wr`, and reports V as zero in both flag sets.
- R10: In 64-bit mode, `icc` is computed on result bits [31:0]. `xcc` is computed on the full 64-bit result, and its V flag reflects only 64-bit signed overflow, with no tag term. In 32-bit mode `xcc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 8 | Operation code 0x20..0x23 |
| src_a | input | DW | First operand |
| src_b | input | DW | Second operand |
| out_valid | output | 1 | Result registered this cycle |
| result | output | DW | Sum or difference |
| icc | output | 4 | 32-bit flags {N,Z,V,C} |
| xcc | output | 4 | 64-bit flags {N,Z,V,C}, zero in 32-bit mode |
| wr_en | output | 1 | Destination write enable pulse |
| flag_wr | output | 1 | Flag update pulse |
| trap_req | output | 1 | Tag-overflow trap pulse |
| trap_code | output | 8 | Trap type, valid with `trap_req` |

## Verification
Every output is due on the first rising edge after the cycle in which the operation was presented. The bench applies each operand pair at a falling edge and samples all outputs at the next falling edge. By then exactly one register stage has loaded them, and no process ordering at the edge can affect the values read. The pulse outputs are checked low again one cycle later. The held `result` is compared after both an idle cycle and an illegal code. A 64-bit and a 32-bit instance receive the same stimulus, so both trap codes and the low-word flag derivation are covered.

// File: rtl/tag_alu_pkg.sv
// Package: shared codes and the flag vector type for the tagged ALU.
// Assumes op codes 0x20..0x23 with bit0 = subtract, bit1 = trapping form.
package tag_alu_pkg;

    localparam logic [5:0] OP_GROUP   = 6'b001000;
    localparam logic [7:0] OP_TADD    = 8'h20;
    localparam logic [7:0] OP_TSUB    = 8'h21;
    localparam logic [7:0] OP_TADD_TV = 8'h22;
    localparam logic [7:0] OP_TSUB_TV = 8'h23;

    localparam logic [7:0] TRAP_CODE_NARROW = 8'h0a;
    localparam logic [7:0] TRAP_CODE_WIDE   = 8'h23;

    // Condition flags, packed N,Z,V,C from bit 3 down to bit 0.
    typedef struct packed {
        logic neg;
        logic zero;
        logic ovf;
        logic cry;
    } ccr_t;

endpackage

// File: rtl/tag_alu_arith.sv
// Adder core: one carry-chain adder computing a+b or a-b (a + ~b + 1).
// It recovers the carry and the signed overflow at bit 31 and at the top
// bit from the sum bits, and it flags a nonzero tag in either operand.
// Assumes DW >= 32.
module tag_alu_arith #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic          sub_sel,
    output logic [DW-1:0] sum,
    output logic          lo_cout,
    output logic          lo_sovf,
    output logic          full_cout,
    output logic          full_sovf,
    output logic          tag_bad
);
    localparam int LO_MSB = 31;
    localparam int TAG_W  = 2;

    logic [DW-1:0] opb_eff;
    logic [DW:0]   ext;
    logic          lo_cin;
    logic          top_cin;

    // Invert the second operand for subtract; the carry-in supplies the +1.
    always_comb opb_eff = sub_sel ? ~opb : opb;

    // Full-width add with carry-out.
    always_comb ext = {1'b0, opa} + {1'b0, opb_eff} + {{DW{1'b0}}, sub_sel};

    // Split the sum and recover the carries into bit 31 and the top bit.
    always_comb begin
        sum       = ext[DW-1:0];
        full_cout = ext[DW];
        lo_cin    = sum[LO_MSB] ^ opa[LO_MSB] ^ opb_eff[LO_MSB];
        top_cin   = sum[DW-1] ^ opa[DW-1] ^ opb_eff[DW-1];
    end

    // Carry out of bit 31 and the signed overflow flags.
    always_comb begin
        lo_cout   = (opa[LO_MSB] & opb_eff[LO_MSB]) |
                    (lo_cin & (opa[LO_MSB] ^ opb_eff[LO_MSB]));
        lo_sovf   = lo_cin ^ lo_cout;
        full_sovf = top_cin ^ full_cout;
    end

    // A nonzero tag in either operand.
    always_comb tag_bad = (|opa[TAG_W-1:0]) | (|opb[TAG_W-1:0]);

endmodule

// File: rtl/tag_alu_flags.sv
// Flag builder: forms the 32-bit (low word) and full-width flag sets from
// the adder outputs. Carry becomes a borrow for subtract. In the plain forms
// the tag check is folded into the 32-bit V only; the trapping forms clear V.
module tag_alu_flags
    import tag_alu_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic [DW-1:0] sum,
    input  logic          lo_cout,
    input  logic          lo_sovf,
    input  logic          full_cout,
    input  logic          full_sovf,
    input  logic          tag_bad,
    input  logic          sub_sel,
    input  logic          trap_var,
    output ccr_t          icc_raw,
    output ccr_t          xcc_raw
);
    localparam int LO_W = 32;

    // 32-bit flags from the low word.
    always_comb begin
        icc_raw.neg  = sum[LO_W-1];
        icc_raw.zero = (sum[LO_W-1:0] == '0);
        icc_raw.ovf  = trap_var ? 1'b0 : (lo_sovf | tag_bad);
        icc_raw.cry  = sub_sel ? ~lo_cout : lo_cout;
    end

    // Full-width flags; no tag term in V.
    always_comb begin
        xcc_raw.neg  = sum[DW-1];
        xcc_raw.zero = (sum == '0);
        xcc_raw.ovf  = trap_var ? 1'b0 : full_sovf;
        xcc_raw.cry  = sub_sel ? ~full_cout : full_cout;
    end

endmodule

// File: rtl/tag_alu_decide.sv
// Decision logic: decodes the op code, and chooses between trap and commit
// for an accepted operation. Assumes the trap test uses the 32-bit overflow.
module tag_alu_decide
    import tag_alu_pkg::*;
(
    input  logic       in_valid,
    input  logic [7:0] op_sel,
    input  logic       tag_bad,
    input  logic       lo_sovf,
    output logic       accept,
    output logic       sub_sel,
    output logic       trap_var,
    output logic       trap_fire,
    output logic       commit
);
    // Decode the operation group and its two mode bits.
    always_comb begin
        accept   = in_valid && (op_sel[7:2] == OP_GROUP);
        sub_sel  = op_sel[0];
        trap_var = op_sel[1];
    end

    // Trap or commit for an accepted operation.
    always_comb begin
        trap_fire = accept && trap_var && (tag_bad || lo_sovf);
        commit    = accept && !trap_fire;
    end

endmodule

// File: rtl/tag_alu.sv
// Top level of the tagged add/subtract unit. WIDE64 selects the 64-bit data
// path with a second flag set. All outputs are registered one cycle after
// the input. On a trap the data outputs are zeroed and no write is issued.
module tag_alu
    import tag_alu_pkg::*;
#(
    parameter bit WIDE64 = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [7:0]                  op_sel,
    input  logic [(WIDE64 ? 64:32)-1:0] src_a,
    input  logic [(WIDE64 ? 64:32)-1:0] src_b,
    output logic                        out_valid,
    output logic [(WIDE64 ? 64:32)-1:0] result,
    output logic [3:0]                  icc,
    output logic [3:0]                  xcc,
    output logic                        wr_en,
    output logic                        flag_wr,
    output logic                        trap_req,
    output logic [7:0]                  trap_code
);
    localparam int         DW      = WIDE64 ? 64 : 32;
    localparam logic [7:0] TRAP_TT = WIDE64 ? TRAP_CODE_WIDE : TRAP_CODE_NARROW;

    logic [DW-1:0] sum;
    logic lo_cout, lo_sovf, full_cout, full_sovf, tag_bad;
    logic accept, sub_sel, trap_var, trap_fire, commit;
    ccr_t icc_raw, xcc_raw, xcc_sel;

    tag_alu_arith #(.DW(DW)) arith_i (
        .opa(src_a), .opb(src_b), .sub_sel(sub_sel), .sum(sum),
        .lo_cout(lo_cout), .lo_sovf(lo_sovf),
        .full_cout(full_cout), .full_sovf(full_sovf), .tag_bad(tag_bad)
    );

    tag_alu_decide decide_i (
        .in_valid(in_valid), .op_sel(op_sel), .tag_bad(tag_bad),
        .lo_sovf(lo_sovf), .accept(accept), .sub_sel(sub_sel),
        .trap_var(trap_var), .trap_fire(trap_fire), .commit(commit)
    );

    tag_alu_flags #(.DW(DW)) flags_i (
        .sum(sum), .lo_cout(lo_cout), .lo_sovf(lo_sovf),
        .full_cout(full_cout), .full_sovf(full_sovf), .tag_bad(tag_bad),
        .sub_sel(sub_sel), .trap_var(trap_var),
        .icc_raw(icc_raw), .xcc_raw(xcc_raw)
    );

    // The 64-bit flag set exists only in wide mode.
    always_comb xcc_sel = WIDE64 ? xcc_raw : '0;

    // Output register stage: the pulses follow each accepted op; the data is held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            icc       <= '0;
            xcc       <= '0;
            wr_en     <= 1'b0;
            flag_wr   <= 1'b0;
            trap_req  <= 1'b0;
            trap_code <= '0;
        end else begin
            out_valid <= accept;
            wr_en     <= commit;
            flag_wr   <= commit;
            trap_req  <= trap_fire;
            trap_code <= trap_fire ? TRAP_TT : 8'h00;
            if (accept) begin
                result <= trap_fire ? '0 : sum;
                icc    <= trap_fire ? '0 : icc_raw;
                xcc    <= trap_fire ? '0 : xcc_sel;
            end
        end
    end

    // Assertions placed next to the output stage.
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !trap_req && !wr_en && result == '0));

    a_r2_valid_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid));

    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && !out_valid));

    a_r8_trap_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (!wr_en && !flag_wr && out_valid && result == '0));

    a_r8_trap_code: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> (trap_code == TRAP_TT));

    a_r8_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> (trap_code == 8'h00));

    a_r9_tv_v_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel[1]) |=> (!icc[1] && !xcc[1]));

    a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot({wr_en, trap_req}));

endmodule

// File: tb/tag_alu_tb_top.sv
// Directed bench: a 64-bit and a 32-bit instance receive the same stimulus,
// and each scenario task compares all outputs with a model built from the
// requirements.
module tag_alu_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  op_sel = 8'h00;
    logic [63:0] a = '0, b = '0;

    logic        ov64, we64, fw64, tr64;
    logic [63:0] res64;
    logic [3:0]  icc64, xcc64;
    logic [7:0]  tc64;
    logic        ov32, we32, fw32, tr32;
    logic [31:0] res32;
    logic [3:0]  icc32, xcc32;
    logic [7:0]  tc32;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [63:0] hold64 = '0, hold32 = '0;

    always #10 clk = ~clk;

    tag_alu dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src_a(a), .src_b(b), .out_valid(ov64), .result(res64), .icc(icc64),
        .xcc(xcc64), .wr_en(we64), .flag_wr(fw64), .trap_req(tr64), .trap_code(tc64)
    );

    tag_alu #(.WIDE64(1'b0)) dut32_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src_a(a[31:0]), .src_b(b[31:0]), .out_valid(ov32), .result(res32), .icc(icc32),
        .xcc(xcc32), .wr_en(we32), .flag_wr(fw32), .trap_req(tr32), .trap_code(tc32)
    );

    task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    // Reference model from the requirements (R3..R10).
    task automatic model(input logic [63:0] ai, bi, input logic [7:0] op, input bit wide,
                         output logic [63:0] r, output logic [3:0] ic, xc,
                         output bit we, tp, output logic [7:0] code);
        logic [63:0] x, y, s;
        logic [31:0] x32, y32, s32;
        bit sub, tv, tag, vl, vf, cl, cf;
        x = wide ? ai : {32'h0, ai[31:0]};
        y = wide ? bi : {32'h0, bi[31:0]};
        sub = op[0];
        tv  = op[1];
        s = sub ? x - y : x + y;
        if (!wide) s = {32'h0, s[31:0]};
        x32 = x[31:0]; y32 = y[31:0]; s32 = s[31:0];
        tag = (x[1:0] != 0) || (y[1:0] != 0);
        cl = sub ? (x32 < y32) : (s32 < x32);
        vl = sub ? (x32[31] != y32[31] && s32[31] != x32[31])
                 : (x32[31] == y32[31] && s32[31] != x32[31]);
        cf = sub ? (x < y) : (s < x);
        vf = sub ? (x[63] != y[63] && s[63] != x[63])
                 : (x[63] == y[63] && s[63] != x[63]);
        ic = {s32[31], s32 == 0, tv ? 1'b0 : (vl | tag), cl};
        xc = wide ? {s[63], s == 0, tv ? 1'b0 : vf, cf} : 4'h0;
        tp = tv && (tag || vl);
        we = !tp;
        code = tp ? (wide ? 8'h23 : 8'h0a) : 8'h00;
        r = s;
        if (tp) begin r = '0; ic = '0; xc = '0; end
    endtask

    // Drive one op at a falling edge; sample one cycle later; check pulses drop.
    task automatic apply(input string req, input logic [63:0] ai, bi, input logic [7:0] op);
        logic [63:0] r; logic [3:0] ic, xc; bit we, tp; logic [7:0] code;
        @(negedge clk);
        a = ai; b = bi; op_sel = op; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        model(ai, bi, op, 1'b1, r, ic, xc, we, tp, code);
        chk(req, "w64 out_valid", {63'h0, ov64}, 64'h1);
        chk(req, "w64 result", res64, r);
        chk(req, "w64 icc", {60'h0, icc64}, {60'h0, ic});
        chk(req, "w64 xcc", {60'h0, xcc64}, {60'h0, xc});
        chk(req, "w64 wr_en", {63'h0, we64}, {63'h0, we});
        chk(req, "w64 flag_wr", {63'h0, fw64}, {63'h0, we});
        chk(req, "w64 trap_req", {63'h0, tr64}, {63'h0, tp});
        chk(req, "w64 trap_code", {56'h0, tc64}, {56'h0, code});
        hold64 = r;
        model(ai, bi, op, 1'b0, r, ic, xc, we, tp, code);
        chk(req, "w32 out_valid", {63'h0, ov32}, 64'h1);
        chk(req, "w32 result", {32'h0, res32}, r);
        chk(req, "w32 icc", {60'h0, icc32}, {60'h0, ic});
        chk(req, "w32 xcc", {60'h0, xcc32}, 64'h0);
        chk(req, "w32 wr_en", {63'h0, we32}, {63'h0, we});
        chk(req, "w32 trap_req", {63'h0, tr32}, {63'h0, tp});
        chk(req, "w32 trap_code", {56'h0, tc32}, {56'h0, code});
        hold32 = r;
        @(negedge clk);
        chk("R2", "pulses drop", {60'h0, ov64, we64, tr64, ov32}, 64'h0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "reset outputs 64", {res64[59:0], icc64} | {56'h0, tc64} | {63'h0, ov64 | we64 | fw64 | tr64} | {60'h0, xcc64}, 64'h0);
        chk("R1", "reset outputs 32", {res32, 20'h0, icc32, tc32} | {63'h0, ov32 | we32 | tr32}, 64'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_add_plain();
        apply("R3", 64'h100, 64'h200, 8'h20);
        apply("R4", 64'h101, 64'h4, 8'h20);
        apply("R5", 64'h7FFF_FFFC, 64'h4, 8'h20);
    endtask

    task automatic t_sub_plain();
        apply("R7", 64'h40, 64'h40, 8'h21);
        apply("R6", 64'h4, 64'h8, 8'h21);
        apply("R5", 64'h8000_0000, 64'h4, 8'h21);
        apply("R4", 64'h10, 64'h2, 8'h21);
    endtask

    task automatic t_wide();
        apply("R10", 64'hFFFF_FFFF_FFFF_FFFC, 64'h4, 8'h20);
        apply("R10", 64'h7FFF_FFFF_FFFF_FFFC, 64'h4, 8'h20);
        apply("R10", 64'h8000_0000_0000_0000, 64'h4, 8'h21);
    endtask

    task automatic t_trap();
        apply("R8", 64'h3, 64'h8, 8'h22);
        apply("R8", 64'h8000_0000, 64'h4, 8'h23);
        apply("R8", 64'h10, 64'h1, 8'h23);
    endtask

    task automatic t_tv_clean();
        apply("R9", 64'h10, 64'h20, 8'h22);
        apply("R9", 64'h10, 64'h20, 8'h23);
        apply("R9", 64'h7FFF_FFFF_FFFF_FFFC, 64'h4, 8'h22);
    endtask

    task automatic t_illegal();
        @(negedge clk);
        a = 64'h1234; b = 64'h8; op_sel = 8'h24; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2", "illegal no pulse", {60'h0, ov64, we64, tr64, ov32}, 64'h0);
        chk("R2", "illegal hold 64", res64, hold64);
        chk("R2", "illegal hold 32", {32'h0, res32}, hold32);
        op_sel = 8'h20;
        @(negedge clk);
        chk("R2", "idle hold 64", res64, hold64);
        chk("R2", "idle no pulse", {62'h0, ov64, fw64}, 64'h0);
    endtask

    initial begin
        t_reset();
        t_add_plain();
        t_sub_plain();
        t_wide();
        t_trap();
        t_tv_clean();
        t_illegal();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule